// File: doc/BRIEF.md
# Dual-Tap Self-Synchronizing Bit Scrambler

This block scrambles a serial transmit stream at the line bit rate, one bit for each bit strobe. A 23-stage history register holds the most recent scrambled output bits. Each scrambled bit is the incoming bit XOR two bits taken from that history. One tap is always the bit sent 23 scrambled bits earlier. The other tap is chosen by a select input: the bit from 18 scrambled bits back for the remote-to-central direction, or from 5 back for the central-to-remote direction. The history is fed from the output, so the scrambler is self-synchronizing. A far-end descrambler that uses the same taps recovers the data once it has received 23 scrambled bits, whatever state it started in.

Framing positions such as sync words and stuff bits are marked by a bypass qualifier. These bits, and every bit sent while scrambling is disabled, leave the block unchanged and do not advance the history. Every bit strobe is sorted into one of three kinds: IDLE (no strobe), PASS (strobe with bypass set or scrambling off) and SCRAMBLE (strobe, no bypass, scrambling on). The kind is chosen afresh on every cycle from the inputs, so a bit of any kind may follow any other. The output stage registers the kind with the output bit. PASS and SCRAMBLE both drive the output strobe. IDLE keeps the last output bit.

Top module: `line_scrambler`

## Requirements
- R1: After reset, bit_o and bit_valid_o are 0 and the history is all zeros, so an all-zero stream scrambled right after reset comes out all zeros.
- R2: With tap_sel_i = 0, each SCRAMBLE bit is output as bit_i XOR y[n-18] XOR y[n-23], where y[n-k] is the k-th previous scrambled output bit.
- R3: With tap_sel_i = 1, each SCRAMBLE bit is output as bit_i XOR y[n-5] XOR y[n-23].
- R4: While scr_on_i = 0, a strobed bit is output unchanged and the history does not advance.
- R5: A strobed bit with bypass_i = 1 is output unchanged and does not advance the history, whatever the value of scr_on_i.
- R6: bit_valid_o equals bit_valid_i delayed by one cycle. The output bit for a strobe appears in that same cycle, and bit_o keeps its value on cycles with no strobe.
- R7: The history is loaded with the scrambled output bit. A descrambler that starts from any state recovers the input without error after 23 received scrambled bits.
- R8: A change of tap_sel_i takes effect on the next SCRAMBLE bit and does not clear the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | Strobe: bit_i carries a bit this cycle |
| bit_i | input | 1 | Serial input bit |
| bypass_i | input | 1 | Marks a sync or stuff position that is sent unscrambled |
| scr_on_i | input | 1 | 1 scrambles, 0 passes data through |
| tap_sel_i | input | 1 | 0 selects taps 18/23, 1 selects taps 5/23 |
| bit_o | output | 1 | Output bit, registered |
| bit_valid_o | output | 1 | Output strobe, one cycle after bit_valid_i |

## Verification
The scrambler is driven with all-zero, all-one, alternating and pseudo-random data on each tap setting. Every output bit is compared with a reference polynomial model. The zero pattern right after reset shows that the history starts clear. The periodic patterns give different results for taps 5 and 18, so swapped taps show up. Bypass and disable bits are mixed into scrambled runs, and the scrambled bits after them show whether the history was frozen or wrongly advanced. A descrambler started from a different state checks the round trip. It also checks that the taps change without a flush when the select flips in mid-stream.

// File: rtl/scr_pkg.sv
package scr_pkg;
    typedef enum logic [1:0] {
        KIND_IDLE     = 2'd0,
        KIND_PASS     = 2'd1,
        KIND_SCRAMBLE = 2'd2
    } bit_kind_t;
endpackage

// File: rtl/scr_bit_class.sv
module scr_bit_class
    import scr_pkg::*;
(
    input  logic      bit_valid_i,
    input  logic      bypass_i,
    input  logic      scr_on_i,
    output bit_kind_t kind_o
);
    always_comb begin
        if (!bit_valid_i)
            kind_o = KIND_IDLE;
        else if (bypass_i || !scr_on_i)
            kind_o = KIND_PASS;
        else
            kind_o = KIND_SCRAMBLE;
    end
endmodule

// File: rtl/scr_history.sv
module scr_history #(
    parameter int STAGES = 23,
    parameter int TAP_A  = 18,
    parameter int TAP_B  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    input  logic              tap_sel_i,
    input  logic              new_bit_i,
    output logic              fb_o,
    output logic [STAGES-1:0] hist_o
);
    localparam int IDX_LONG = STAGES - 1;
    localparam int IDX_A    = TAP_A - 1;
    localparam int IDX_B    = TAP_B - 1;

    logic [STAGES-1:0] hist_q;
    logic [STAGES-1:0] hist_next;

    // hist_q[k] holds the output from k+1 scrambled bits ago
    assign hist_next[0] = new_bit_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_shift
        assign hist_next[g] = hist_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else if (advance_i)
            hist_q <= hist_next;
    end

    assign fb_o   = hist_q[IDX_LONG] ^ (tap_sel_i ? hist_q[IDX_B] : hist_q[IDX_A]);
    assign hist_o = hist_q;
endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage
    import scr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bit_kind_t kind_i,
    input  logic      raw_bit_i,
    input  logic      scr_bit_i,
    output logic      bit_o,
    output logic      bit_valid_o
);
    bit_kind_t kind_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            kind_q <= KIND_IDLE;
        else
            kind_q <= kind_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_o <= 1'b0;
        end else begin
            unique case (kind_i)
                KIND_IDLE:     bit_o <= bit_o;
                KIND_PASS:     bit_o <= raw_bit_i;
                KIND_SCRAMBLE: bit_o <= scr_bit_i;
                default:       bit_o <= bit_o;
            endcase
        end
    end

    assign bit_valid_o = (kind_q != KIND_IDLE);
endmodule

// File: rtl/line_scrambler.sv
module line_scrambler
    import scr_pkg::*;
#(
    parameter int STAGES = 23,
    parameter int TAP_A  = 18,
    parameter int TAP_B  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid_i,
    input  logic bit_i,
    input  logic bypass_i,
    input  logic scr_on_i,
    input  logic tap_sel_i,
    output logic bit_o,
    output logic bit_valid_o
);
    bit_kind_t         kind_w;
    logic              fb_w;
    logic              scr_bit_w;
    logic              advance_w;
    logic [STAGES-1:0] hist_w;

    scr_bit_class u_class (
        .bit_valid_i (bit_valid_i),
        .bypass_i    (bypass_i),
        .scr_on_i    (scr_on_i),
        .kind_o      (kind_w)
    );

    assign scr_bit_w = bit_i ^ fb_w;
    assign advance_w = (kind_w == KIND_SCRAMBLE);

    scr_history #(
        .STAGES (STAGES),
        .TAP_A  (TAP_A),
        .TAP_B  (TAP_B)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance_w),
        .tap_sel_i (tap_sel_i),
        .new_bit_i (scr_bit_w),
        .fb_o      (fb_w),
        .hist_o    (hist_w)
    );

    scr_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .kind_i      (kind_w),
        .raw_bit_i   (bit_i),
        .scr_bit_i   (scr_bit_w),
        .bit_o       (bit_o),
        .bit_valid_o (bit_valid_o)
    );
endmodule

// File: rtl/line_scrambler_chk.sv
module line_scrambler_chk #(
    parameter int STAGES = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_valid_i,
    input logic              bit_i,
    input logic              bypass_i,
    input logic              scr_on_i,
    input logic              bit_o,
    input logic              bit_valid_o,
    input logic [STAGES-1:0] hist_w
);
    p_strobe_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bit_valid_o == $past(bit_valid_i)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid_i |=> $stable(bit_o));

    p_bypass_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && bypass_i) |=> (bit_o == $past(bit_i)));

    p_off_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && !scr_on_i) |=> (bit_o == $past(bit_i)));

    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid_i && scr_on_i && !bypass_i) |=> $stable(hist_w));

    p_hist_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_i && scr_on_i && !bypass_i) |=> (hist_w[0] == bit_o));
endmodule

bind line_scrambler line_scrambler_chk #(.STAGES(STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .bypass_i    (bypass_i),
    .scr_on_i    (scr_on_i),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .hist_w      (hist_w)
);

// File: tb/test_line_scrambler.sv
`timescale 1ns/1ps
module test_line_scrambler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid_i = 1'b0;
    logic bit_i = 1'b0;
    logic bypass_i = 1'b0;
    logic scr_on_i = 1'b0;
    logic tap_sel_i = 1'b0;
    logic bit_o;
    logic bit_valid_o;

    int vectors = 0;
    int errors = 0;
    logic [22:0] m_hist = '0;   // bench model of scrambled history
    logic [22:0] d_hist = '0;   // descrambler history
    logic [31:0] prng = 32'h1d2c_3b4a;

    always #2.5 clk = ~clk;

    line_scrambler i_line_scrambler (
        .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid_i), .bit_i(bit_i),
        .bypass_i(bypass_i), .scr_on_i(scr_on_i), .tap_sel_i(tap_sel_i),
        .bit_o(bit_o), .bit_valid_o(bit_valid_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_rand();
        prng = prng ^ (prng << 13);
        prng = prng ^ (prng >> 17);
        prng = prng ^ (prng << 5);
        return prng[0];
    endfunction

    // reference: output and history update for one strobed bit
    function automatic logic model_bit(input logic b, input logic byp,
                                       input logic on, input logic sel);
        logic y;
        if (byp || !on) return b;
        y = b ^ m_hist[22] ^ (sel ? m_hist[4] : m_hist[17]);
        m_hist = {m_hist[21:0], y};
        return y;
    endfunction

    function automatic logic descramble(input logic r, input logic sel);
        logic d;
        d = r ^ d_hist[22] ^ (sel ? d_hist[4] : d_hist[17]);
        d_hist = {d_hist[21:0], r};
        return d;
    endfunction

    // drive one bit (called just after a negedge), check after the capturing edge
    task automatic push(input string req, input logic b, input logic byp,
                        input logic on, input logic sel, output logic got);
        logic exp;
        exp = model_bit(b, byp, on, sel);
        bit_valid_i = 1'b1; bit_i = b; bypass_i = byp; scr_on_i = on; tap_sel_i = sel;
        @(posedge clk); #1;
        check(req, bit_valid_o, 1'b1);
        check(req, bit_o, exp);
        got = bit_o;
        @(negedge clk);
        bit_valid_i = 1'b0;
    endtask

    function automatic logic pattern(input int kind, input int i);
        case (kind)
            0: return 1'b0;
            1: return 1'b1;
            2: return i[0];
            default: return next_rand();
        endcase
    endfunction

    task automatic test_reset();
        logic g;
        check("R1", bit_o, 1'b0);
        check("R1", bit_valid_o, 1'b0);
        for (int i = 0; i < 40; i++) begin
            push("R1", 1'b0, 1'b0, 1'b1, 1'b0, g);
            check("R1", g, 1'b0);
        end
    endtask

    task automatic test_taps(input logic sel, input string req);
        logic g;
        for (int k = 1; k < 4; k++)
            for (int i = 0; i < 120; i++)
                push(req, pattern(k, i), 1'b0, 1'b1, sel, g);
    endtask

    task automatic test_disable();
        logic g;
        for (int i = 0; i < 30; i++) push("R4", next_rand(), 1'b0, 1'b0, 1'b0, g);
        for (int i = 0; i < 40; i++) push("R4", next_rand(), 1'b0, 1'b1, 1'b0, g);
    endtask

    task automatic test_bypass();
        logic g;
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 14; i++) push("R5", next_rand(), 1'b1, 1'b1, f[0], g);
            for (int i = 0; i < 30; i++) push("R5", next_rand(), 1'b0, 1'b1, f[0], g);
            for (int i = 0; i < 4; i++)  push("R5", next_rand(), 1'b1, 1'b0, f[0], g);
            for (int i = 0; i < 10; i++) push("R5", next_rand(), 1'b0, 1'b1, f[0], g);
        end
    endtask

    task automatic test_idle();
        logic g, held;
        push("R6", 1'b1, 1'b1, 1'b1, 1'b0, g);
        held = g;
        for (int i = 0; i < 5; i++) begin
            bit_i = ~bit_i;
            @(posedge clk); #1;
            check("R6", bit_valid_o, 1'b0);
            check("R6", bit_o, held);
            @(negedge clk);
        end
    endtask

    task automatic test_switch();
        logic g;
        for (int s = 0; s < 6; s++)
            for (int i = 0; i < 17; i++)
                push("R8", next_rand(), 1'b0, 1'b1, s[0], g);
    endtask

    task automatic test_roundtrip(input logic sel);
        logic g, d, src;
        d_hist = 23'h5a5a5;
        for (int i = 0; i < 200; i++) begin
            src = next_rand();
            push("R7", src, 1'b0, 1'b1, sel, g);
            d = descramble(g, sel);
            if (i >= 23) check("R7", d, src);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        #1;
        test_reset_pre();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_taps(1'b0, "R2");
        test_taps(1'b1, "R3");
        test_disable();
        test_bypass();
        test_idle();
        test_switch();
        test_roundtrip(1'b0);
        test_roundtrip(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic test_reset_pre();
        check("R1", bit_o, 1'b0);
        check("R1", bit_valid_o, 1'b0);
    endtask
endmodule